// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Timing Mode and Programmable Thresholds

This block is a first-in first-out buffer for 9-bit words, written from one clock domain and read from another. Its depth is a power of two set by a parameter. A master reset fixes one of two timing modes. In standard mode, a word appears on the output only after a read request, and the status pins report empty and full. In fall-through mode, the oldest word moves to the output on its own, and the status pins report that the output holds a word and that there is room to write.

Three threshold flags are available in both modes. The half-full flag is built in. The almost-empty and almost-full flags use offsets that the user can program. The offsets are loaded either a word at a time through the data inputs, or a bit at a time through a serial input. A partial reset empties the buffer and keeps the programmed offsets. A master reset also restores the default offsets.

A rewind input sets the read side back to the first stored location, so data that has already been read can be read again. Flow control on both sides is enable-based. The writer must treat the write-side status as back-pressure, because a write into a full buffer is dropped. The reader may only take a word while the read-side status shows that one is present, because a read with nothing stored is ignored.

Top module: `dual_mode_fifo`

## Requirements
- R1: With `ld_n` high, a write-clock edge with `wen_n` low stores `din` unless the buffer is full. Words are returned in the order they were written.
- R2: `mode_fwft` is captured on every write-clock edge while `mrs_n` is low. A value of 1 selects fall-through mode and 0 selects standard mode. Changing `mode_fwft` after `mrs_n` rises has no effect.
- R3: In standard mode, `rd_stat` is 1 while nothing is stored. A read-clock edge with `ren_n` low and data stored puts the oldest word on `dout`. A read while empty leaves `dout` unchanged.
- R4: In fall-through mode, the oldest word reaches `dout` and `rd_stat` rises without any read request. After the last word is presented, `rd_stat` stays 1. The next read that finds nothing stored clears `rd_stat` and leaves `dout` unchanged.
- R5: `wr_stat` equals "full" in standard mode and "not full" in fall-through mode. A write while full changes neither the memory nor the pointers.
- R6: `half_full` is 1 exactly when more than DEPTH/2 words are stored.
- R7: With almost-empty offset n and almost-full offset m, `almost_empty` is 1 when at most n words are stored, and `almost_full` is 1 when more than DEPTH-(m+1) words are stored.
- R8: After a master reset, both offsets equal 127 when DEPTH is at most 1024, and 255 when DEPTH is larger.
- R9: While `ld_n` and `wen_n` are both low, each write-clock edge loads `din` into the next slice of the offsets. The order is: the almost-empty slices from least significant up, then the almost-full slices, then back to the start. Nothing is written into the buffer during loading.
- R10: Each write-clock edge with `sen_n` low shifts `si` into the next offset bit. The almost-empty offset is filled first, least significant bit first, then the almost-full offset.
- R11: A low on `prs_n` empties the buffer and resets the flags and `dout`, and keeps the programmed offsets.
- R12: A low on `mrs_n` does everything a partial reset does and also restores the default offsets.
- R13: A read-clock edge with `rt_n` low moves the read position back to location 0. Later reads repeat the stored data, and the write position does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrs_n | input | 1 | Master reset, active low, asynchronous |
| prs_n | input | 1 | Partial reset, active low, asynchronous |
| mode_fwft | input | 1 | Timing-mode select, sampled during master reset |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data, or an offset slice while loading |
| ld_n | input | 1 | Parallel offset load select, active low |
| sen_n | input | 1 | Serial offset shift enable, active low |
| si | input | 1 | Serial offset bit |
| ren_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Rewind request, active low |
| dout | output | DW | Read data register |
| rd_stat | output | 1 | Empty in standard mode, output-valid in fall-through mode |
| wr_stat | output | 1 | Full in standard mode, input-ready in fall-through mode |
| half_full | output | 1 | More than half the depth is occupied |
| almost_empty | output | 1 | Stored words are at or below the almost-empty offset |
| almost_full | output | 1 | Stored words are above depth minus (almost-full offset + 1) |

## Verification
The bench builds the block with DEPTH = 256. This gives 8-bit offsets, so each offset loads in a single parallel slice and a serial load takes sixteen bits. At this depth the bench can fill the buffer completely and drain it in a few thousand cycles. It therefore reaches the full condition, the dropped write, the half-full boundary and both offset boundaries, using the default, parallel-loaded and serially loaded offsets. Only the 127 default is covered; the 255 default for larger depths is not built.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;

  // Offset loaded by master reset, chosen by address width
  function automatic int def_ofs(input int aw);
    return (aw > 10) ? 255 : 127;
  endfunction
endpackage

// File: rtl/dmf_ptr_sync.sv
module dmf_ptr_sync #(
  parameter int W = 11
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] bin_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] g_src, g_meta, g_sync;

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) g_src <= '0;
    else        g_src <= bin_in ^ (bin_in >> 1);

  always_ff @(posedge dst_clk or negedge rst_n)
    if (!rst_n) begin
      g_meta <= '0;
      g_sync <= '0;
    end else begin
      g_meta <= g_src;
      g_sync <= g_meta;
    end

  for (genvar i = 0; i < W; i++) begin : g_bin
    assign bin_out[i] = ^g_sync[W-1:i];
  end
endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side
  import dmf_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          mrs_n,
  input  logic          fwft,
  input  logic          wen_n,
  input  logic          ld_n,
  input  logic          sen_n,
  input  logic          si,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   rptr_s,
  output logic [AW:0]   wptr,
  output logic          we,
  output logic          wr_stat,
  output logic          half_full,
  output logic          almost_full,
  output logic [AW-1:0] ae_ofs
);
  localparam int OW = AW;
  localparam int CH = (OW + DW - 1) / DW;
  localparam int PW = $clog2(2 * CH);
  localparam int SW = $clog2(2 * OW);
  localparam logic [OW-1:0] DEF      = OW'(def_ofs(AW));
  localparam logic [AW:0]   CNT_FULL = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0]   CNT_HALF = {2'b01, {(AW-1){1'b0}}};
  localparam logic [AW:0]   CNT_TOP  = {1'b0, {AW{1'b1}}};

  logic [2*OW-1:0] ofs_q, p_data, p_mask;
  logic [PW-1:0]   p_idx;
  logic [SW-1:0]   s_idx;
  logic [AW:0]     wcount;
  logic            full, ld_wr;

  assign wcount = wptr - rptr_s;
  assign full   = (wcount == CNT_FULL);
  assign ld_wr  = !ld_n && !wen_n;
  assign we     = !wen_n && ld_n && !full;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n)  wptr <= '0;
    else if (we) wptr <= wptr + 1'b1;

  // Slice position for the current parallel load step
  always_comb begin
    int step, sh;
    step   = int'(p_idx);
    sh     = ((step >= CH) ? OW : 0) + (step % CH) * DW;
    p_data = {{(2*OW-DW){1'b0}}, din} << sh;
    p_mask = ({{(2*OW-DW){1'b0}}, {DW{1'b1}}} << sh) &
             ((step >= CH) ? {{OW{1'b1}}, {OW{1'b0}}} : {{OW{1'b0}}, {OW{1'b1}}});
  end

  always_ff @(posedge wclk or negedge mrs_n)
    if (!mrs_n)      ofs_q <= {DEF, DEF};
    else if (ld_wr)  ofs_q <= (ofs_q & ~p_mask) | (p_data & p_mask);
    else if (!sen_n) ofs_q[s_idx] <= si;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      p_idx <= '0;
      s_idx <= '0;
    end else if (ld_wr) begin
      p_idx <= (p_idx == PW'(2*CH-1)) ? '0 : p_idx + 1'b1;
    end else if (!sen_n) begin
      s_idx <= (s_idx == SW'(2*OW-1)) ? '0 : s_idx + 1'b1;
    end

  assign ae_ofs      = ofs_q[OW-1:0];
  assign wr_stat     = fwft ? !full : full;
  assign half_full   = (wcount > CNT_HALF);
  assign almost_full = (wcount > (CNT_TOP - {1'b0, ofs_q[2*OW-1:OW]}));

  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= CNT_FULL);
  // R9
  load_no_push_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!ld_n && !wen_n) |=> $stable(wptr));
endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          ren_n,
  input  logic          rt_n,
  input  logic [AW:0]   wptr_s,
  input  logic [DW-1:0] rd_word,
  input  logic [AW-1:0] ae_ofs,
  output logic [AW:0]   rptr,
  output logic [DW-1:0] dout,
  output logic          rd_stat,
  output logic          almost_empty
);
  logic          mem_empty, or_q;
  logic [AW:0]   rcount;

  assign rcount    = wptr_s - rptr;
  assign mem_empty = (rcount == '0);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rptr <= '0;
      dout <= '0;
      or_q <= 1'b0;
    end else if (!rt_n) begin
      rptr <= '0;
      or_q <= 1'b0;
    end else if (fwft) begin
      if (!mem_empty && (!or_q || !ren_n)) begin
        dout <= rd_word;
        rptr <= rptr + 1'b1;
        or_q <= 1'b1;
      end else if (!ren_n) begin
        or_q <= 1'b0;
      end
    end else if (!ren_n && !mem_empty) begin
      dout <= rd_word;
      rptr <= rptr + 1'b1;
    end

  assign rd_stat      = fwft ? or_q : mem_empty;
  assign almost_empty = (rcount <= {1'b0, ae_ofs});

  // R3
  empty_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && rt_n && !ren_n && mem_empty) |=> $stable(dout));
  // R4
  ready_drop_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(or_q) |-> $past(!ren_n || !rt_n));
  // R13
  rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rt_n |=> (rptr == '0));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 9
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrs_n,
  input  logic          prs_n,
  input  logic          mode_fwft,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          ld_n,
  input  logic          sen_n,
  input  logic          si,
  input  logic          ren_n,
  input  logic          rt_n,
  output logic [DW-1:0] dout,
  output logic          rd_stat,
  output logic          wr_stat,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);

  fifo_mode_e    mode_q;
  logic          rst_n, fwft, we;
  logic [AW:0]   wptr, rptr, wptr_s, rptr_s;
  logic [AW-1:0] ae_ofs;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_word;

  assign rst_n = mrs_n & prs_n;
  assign fwft  = (mode_q == MODE_FWFT);

  always_ff @(posedge wclk)
    if (!mrs_n) mode_q <= mode_fwft ? MODE_FWFT : MODE_STD;

  always_ff @(posedge wclk)
    if (we) mem[wptr[AW-1:0]] <= din;

  assign rd_word = mem[rptr[AW-1:0]];

  dmf_wr_side #(.AW(AW), .DW(DW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .mrs_n(mrs_n), .fwft(fwft),
    .wen_n(wen_n), .ld_n(ld_n), .sen_n(sen_n), .si(si), .din(din),
    .rptr_s(rptr_s), .wptr(wptr), .we(we), .wr_stat(wr_stat),
    .half_full(half_full), .almost_full(almost_full), .ae_ofs(ae_ofs)
  );

  dmf_rd_side #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .ren_n(ren_n), .rt_n(rt_n),
    .wptr_s(wptr_s), .rd_word(rd_word), .ae_ofs(ae_ofs), .rptr(rptr),
    .dout(dout), .rd_stat(rd_stat), .almost_empty(almost_empty)
  );

  dmf_ptr_sync #(.W(AW+1)) u_w2r (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n), .bin_in(wptr), .bin_out(wptr_s)
  );

  dmf_ptr_sync #(.W(AW+1)) u_r2w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n), .bin_in(rptr), .bin_out(rptr_s)
  );

  // R2
  mode_hold_chk: assert property (@(posedge wclk) disable iff (!mrs_n)
    mrs_n |=> $stable(mode_q));
endmodule

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;
  localparam int DEPTH = 256;
  localparam int DW    = 9;

  logic wclk, rclk, mrs_n, prs_n, mode_fwft, wen_n, ld_n, sen_n, si, ren_n, rt_n;
  logic [DW-1:0] din, dout;
  logic rd_stat, wr_stat, half_full, almost_empty, almost_full;
  int checks = 0, fails = 0;
  bit done = 0;

  dual_mode_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .prs_n(prs_n), .mode_fwft(mode_fwft),
    .wen_n(wen_n), .din(din), .ld_n(ld_n), .sen_n(sen_n), .si(si),
    .ren_n(ren_n), .rt_n(rt_n), .dout(dout), .rd_stat(rd_stat), .wr_stat(wr_stat),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  initial wclk = 0;
  always #4 wclk = ~wclk;
  initial begin
    rclk = 0;
    #3;
    forever #4 rclk = ~rclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_mrs(input logic mode);
    @(negedge wclk);
    mrs_n = 0;
    mode_fwft = mode;
    repeat (4) @(negedge wclk);
    mrs_n = 1;
    settle();
  endtask

  task automatic do_prs();
    @(negedge wclk);
    prs_n = 0;
    repeat (4) @(negedge wclk);
    prs_n = 1;
    settle();
  endtask

  task automatic wr_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen_n = 0;
      din = DW'(base + i);
    end
    @(negedge wclk);
    wen_n = 1;
    settle();
  endtask

  task automatic rd_one(input string req, input int exp);
    @(negedge rclk);
    ren_n = 0;
    @(negedge rclk);
    ren_n = 1;
    chk(req, 32'(dout), exp);
  endtask

  task automatic t_reset_state();
    do_mrs(1'b0);
    chk("R3 empty after reset", 32'(rd_stat), 1);
    chk("R5 not full after reset", 32'(wr_stat), 0);
    chk("R6 half after reset", 32'(half_full), 0);
    chk("R8 almost_empty after reset", 32'(almost_empty), 1);
    chk("R12 almost_full after reset", 32'(almost_full), 0);
    chk("R12 dout after reset", 32'(dout), 0);
  endtask

  task automatic t_std_order();
    wr_burst(5, 9'h0A0);
    chk("R3 not empty", 32'(rd_stat), 0);
    for (int i = 0; i < 5; i++) rd_one("R1 order", 9'h0A0 + i);
    settle();
    chk("R3 empty after drain", 32'(rd_stat), 1);
    rd_one("R3 read while empty keeps dout", 9'h0A4);
  endtask

  task automatic t_thresholds();
    do_mrs(1'b0);
    wr_burst(127, 0);
    chk("R8 ae at 127", 32'(almost_empty), 1);
    wr_burst(1, 127);
    chk("R7 ae at 128", 32'(almost_empty), 0);
    chk("R7 af at 128", 32'(almost_full), 0);
    chk("R6 half at 128", 32'(half_full), 0);
    wr_burst(1, 128);
    chk("R7 af at 129", 32'(almost_full), 1);
    chk("R6 half at 129", 32'(half_full), 1);
    wr_burst(127, 129);
    chk("R5 full at 256", 32'(wr_stat), 1);
    wr_burst(1, 9'h1FF);
    for (int i = 0; i < DEPTH; i++) rd_one("R1 full drain order", i);
    settle();
    chk("R5 write while full dropped", 32'(rd_stat), 1);
  endtask

  task automatic t_parallel();
    do_prs();
    @(negedge wclk);
    ld_n = 0; wen_n = 0; din = 9'd3;
    @(negedge wclk);
    din = 9'd5;
    @(negedge wclk);
    ld_n = 1; wen_n = 1;
    settle();
    chk("R9 no push during load", 32'(rd_stat), 1);
    wr_burst(3, 0);
    chk("R9 ae offset 3 at 3", 32'(almost_empty), 1);
    wr_burst(1, 3);
    chk("R9 ae offset 3 at 4", 32'(almost_empty), 0);
    wr_burst(246, 4);
    chk("R9 af offset 5 at 250", 32'(almost_full), 0);
    wr_burst(1, 250);
    chk("R9 af offset 5 at 251", 32'(almost_full), 1);
    do_prs();
    chk("R11 empty after prs", 32'(rd_stat), 1);
    chk("R11 ae after prs", 32'(almost_empty), 1);
    chk("R11 af after prs", 32'(almost_full), 0);
    chk("R11 half after prs", 32'(half_full), 0);
    wr_burst(4, 0);
    chk("R11 offset kept", 32'(almost_empty), 0);
    do_mrs(1'b0);
    wr_burst(4, 0);
    chk("R12 default offset restored", 32'(almost_empty), 1);
  endtask

  task automatic t_serial();
    logic [15:0] v;
    do_mrs(1'b0);
    v = {8'd10, 8'd2};
    for (int k = 0; k < 16; k++) begin
      @(negedge wclk);
      sen_n = 0;
      si = v[k];
    end
    @(negedge wclk);
    sen_n = 1;
    wr_burst(2, 0);
    chk("R10 ae offset 2 at 2", 32'(almost_empty), 1);
    wr_burst(1, 2);
    chk("R10 ae offset 2 at 3", 32'(almost_empty), 0);
    wr_burst(242, 3);
    chk("R10 af offset 10 at 245", 32'(almost_full), 0);
    wr_burst(1, 245);
    chk("R10 af offset 10 at 246", 32'(almost_full), 1);
  endtask

  task automatic t_fwft();
    do_mrs(1'b1);
    mode_fwft = 0;
    chk("R4 not ready after reset", 32'(rd_stat), 0);
    chk("R5 input ready after reset", 32'(wr_stat), 1);
    wr_burst(3, 9'h040);
    chk("R2 mode kept, word fell", 32'(rd_stat), 1);
    chk("R4 first word on dout", 32'(dout), 9'h040);
    rd_one("R4 second word", 9'h041);
    rd_one("R4 last word", 9'h042);
    chk("R4 ready holds on last", 32'(rd_stat), 1);
    rd_one("R4 dout kept on empty read", 9'h042);
    chk("R4 ready drops", 32'(rd_stat), 0);
  endtask

  task automatic t_rewind();
    do_mrs(1'b0);
    wr_burst(4, 9'h010);
    rd_one("R13 pre read 0", 9'h010);
    rd_one("R13 pre read 1", 9'h011);
    @(negedge rclk);
    rt_n = 0;
    @(negedge rclk);
    rt_n = 1;
    for (int i = 0; i < 4; i++) rd_one("R13 replay", 9'h010 + i);
    settle();
    chk("R13 write pointer unchanged", 32'(rd_stat), 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mrs_n = 1; prs_n = 1; mode_fwft = 0; wen_n = 1; din = '0;
    ld_n = 1; sen_n = 1; si = 0; ren_n = 1; rt_n = 1;
    t_reset_state();
    t_std_order();
    t_thresholds();
    t_parallel();
    t_serial();
    t_fwft();
    t_rewind();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule